// File: doc/BRIEF.md
# Auto-Reload Up-Counter with Compare

The block is an 8-bit up-counter for a register-mapped timer. A small register bus configures it and reads it back. Counting steps come from one of three sources: the core clock, the core clock divided by three, or rising edges of an external input pin. A power-of-two prescaler between 1 and 128 divides that source. When the count passes its all-ones value, it reloads from a reload register and raises a sticky overflow flag. A compare register raises a sticky match flag when a counting step lands on its value.

Software can read the live count at any time. A write to the live count address replaces the count without stopping the timer. The external pin passes through a two-flop synchronizer. When enabled, an edge of a chosen polarity on that pin reloads the count, which keeps the timer in step with outside events. A system reset clears the configuration and the flags but keeps the count itself.

Bus map (3-bit address): 0 control, 1 reload value, 2 compare value, 3 live count, 4 flags (bit 0 overflow, bit 1 compare match; write 1 to clear). Other addresses read as zero and ignore writes.

Top module: `art_timer`

## Requirements
- R1: The control register holds the clock-source select in bits 1-0, edge enable in bit 2, edge polarity in bit 3 (0 rising, 1 falling) and the prescaler select in bits 7-5. All registers read back at the addresses of the bus map.
- R2: With prescaler select n (0..7), the count advances exactly once per 2^n source steps.
- R3: Control bit 4 is reserved and always reads as zero, whatever is written to it.
- R4: Source select 0 steps on every clock, 1 on every third clock, and 2 on each rising edge of the synchronized external pin. Select 3 produces no steps.
- R5: A step taken at count 8'hFF loads the reload value instead of wrapping to zero.
- R6: That step sets the sticky overflow flag (flags bit 0). Writing 1 to the bit clears it, and it stays clear until the next overflow.
- R7: A counting step whose result equals the compare value sets the sticky match flag (flags bit 1). Writing 1 to the bit clears it.
- R8: A write to the live count address sets the count at that clock edge. Reads return the running count, and counting continues from the written value.
- R9: With edge enable set, an edge of the selected polarity on the synchronized pin loads the reload value. The opposite edge, or any edge with edge enable clear, leaves the count unchanged.
- R10: When a live-count write meets an overflow step in the same cycle, the written value is kept and the overflow flag is not set.
- R11: Reset clears the control, reload, compare and flag registers. It leaves the count unchanged and stops all counting while asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| ext_pin | input | 1 | External clock and synchronization input |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmp_flag | output | 1 | Sticky compare-match flag |

## Verification
The assertions assume that bus address and data are valid whenever the write strobe is high, and that the external pin holds each level for at least two clocks, so that the synchronizer passes every edge. The bench drives the pin with pulses three clocks wide and only changes it at falling clock edges. It writes only mapped addresses. It measures prescaler ratios over windows that are whole multiples of the division period, so that the free-running prescaler phase never affects the expected count.

// File: rtl/art_pkg.sv
package art_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_RELOAD = 3'd1,
    A_CMP    = 3'd2,
    A_LIVE   = 3'd3,
    A_FLAGS  = 3'd4
  } reg_addr_e;

  typedef enum logic [1:0] {
    SRC_CORE = 2'd0,
    SRC_DIV3 = 2'd1,
    SRC_PIN  = 2'd2,
    SRC_OFF  = 2'd3
  } src_sel_e;

  // control field positions
  localparam int unsigned F_SRC_LO  = 0;
  localparam int unsigned F_EDGE_EN = 2;
  localparam int unsigned F_EDGE_PL = 3;
  localparam int unsigned F_RSV     = 4;
  localparam int unsigned F_PS_LO   = 5;

  localparam int unsigned FLAG_OVF = 0;
  localparam int unsigned FLAG_CMP = 1;
endpackage

// File: rtl/art_clk_src.sv
module art_clk_src
  import art_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pin,
  input  src_sel_e sel,
  input  logic     edge_en,
  input  logic     edge_fall,
  output logic     src_tick,
  output logic     sync_edge
);
  logic [1:0]             div3_q;
  logic                   div3_pulse;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   pin_s;
  logic                   pin_rise;
  logic                   pin_fall;

  always_ff @(posedge clk) begin
    if (!rst_n) div3_q <= 2'd0;
    else        div3_q <= (div3_q == 2'd2) ? 2'd0 : div3_q + 2'd1;
  end
  assign div3_pulse = (div3_q == 2'd2);

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rst_n) sync_q[g] <= 1'b0;
      else if (g == 0) sync_q[g] <= pin;
      else sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= pin_s;
  end

  assign pin_s    = sync_q[SYNC_STAGES-1];
  assign pin_rise = pin_s & ~prev_q;
  assign pin_fall = ~pin_s & prev_q;

  always_comb begin
    unique case (sel)
      SRC_CORE: src_tick = rst_n;
      SRC_DIV3: src_tick = rst_n & div3_pulse;
      SRC_PIN:  src_tick = rst_n & pin_rise;
      default:  src_tick = 1'b0;
    endcase
  end

  assign sync_edge = rst_n & edge_en & (edge_fall ? pin_fall : pin_rise);
endmodule

// File: rtl/art_prescaler.sv
module art_prescaler #(
  parameter int unsigned SELW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            src_tick,
  input  logic [SELW-1:0] sel,
  output logic            cnt_tick
);
  localparam int unsigned CW = (1 << SELW) - 1;

  logic [CW-1:0] pre_q;
  logic [CW-1:0] mask;

  // low n bits set: the prescaler fires when all of them are ones
  function automatic logic [CW-1:0] ratio_mask(input logic [SELW-1:0] s);
    logic [CW-1:0] m;
    for (int i = 0; i < CW; i++) m[i] = (i < int'(s));
    return m;
  endfunction

  assign mask = ratio_mask(sel);

  always_ff @(posedge clk) begin
    if (!rst_n)        pre_q <= '0;
    else if (src_tick) pre_q <= pre_q + 1'b1;
  end

  assign cnt_tick = rst_n & src_tick & ((pre_q & mask) == mask);
endmodule

// File: rtl/art_core.sv
module art_core #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_tick,
  input  logic          live_wr,
  input  logic [DW-1:0] live_wdata,
  input  logic          edge_reload,
  input  logic [DW-1:0] reload_val,
  input  logic [DW-1:0] cmp_val,
  input  logic [1:0]    flag_clr,
  output logic [DW-1:0] cnt,
  output logic          step,
  output logic          ovf_evt,
  output logic          cmp_evt,
  output logic          ovf_flag,
  output logic          cmp_flag
);
  localparam logic [DW-1:0] CNT_MAX = '1;

  logic [DW-1:0] cnt_q;
  logic [DW-1:0] step_val;

  function automatic logic [DW-1:0] next_count(input logic [DW-1:0] c,
                                               input logic [DW-1:0] rl);
    return (c == CNT_MAX) ? rl : c + 1'b1;
  endfunction

  assign step     = cnt_tick & ~live_wr & ~edge_reload;
  assign step_val = next_count(cnt_q, reload_val);
  assign ovf_evt  = step & (cnt_q == CNT_MAX);
  assign cmp_evt  = step & (step_val == cmp_val);

  // the count is deliberately left out of reset
  always_ff @(posedge clk) begin
    if (live_wr)          cnt_q <= live_wdata;
    else if (edge_reload) cnt_q <= reload_val;
    else if (step)        cnt_q <= step_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0;
      cmp_flag <= 1'b0;
    end else begin
      ovf_flag <= ovf_evt | (ovf_flag & ~flag_clr[0]);
      cmp_flag <= cmp_evt | (cmp_flag & ~flag_clr[1]);
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/art_timer.sv
module art_timer
  import art_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter int unsigned PSW         = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              ext_pin,
  output logic              ovf_flag,
  output logic              cmp_flag
);
  localparam logic [DW-1:0] CTRL_WMASK = ~(DW'(1) << F_RSV);

  logic [DW-1:0] ctrl_q;
  logic [DW-1:0] reload_q;
  logic [DW-1:0] cmp_q;
  logic [DW-1:0] cnt;
  logic          wr_ok;
  logic          live_wr;
  logic [1:0]    flag_clr;
  logic          src_tick;
  logic          cnt_tick;
  logic          edge_reload;
  logic          step;
  logic          ovf_evt;
  logic          cmp_evt;
  src_sel_e      src_sel;
  logic [PSW-1:0] ps_sel;

  assign wr_ok    = rst_n & bus_wr;
  assign live_wr  = wr_ok & (bus_addr == A_LIVE);
  assign flag_clr = (wr_ok & (bus_addr == A_FLAGS)) ?
                    {bus_wdata[FLAG_CMP], bus_wdata[FLAG_OVF]} : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      reload_q <= '0;
      cmp_q    <= '0;
    end else if (bus_wr) begin
      unique case (bus_addr)
        A_CTRL:   ctrl_q   <= bus_wdata & CTRL_WMASK;
        A_RELOAD: reload_q <= bus_wdata;
        A_CMP:    cmp_q    <= bus_wdata;
        default:  ;
      endcase
    end
  end

  assign src_sel = src_sel_e'(ctrl_q[F_SRC_LO +: 2]);
  assign ps_sel  = ctrl_q[F_PS_LO +: PSW];

  art_clk_src #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin       (ext_pin),
    .sel       (src_sel),
    .edge_en   (ctrl_q[F_EDGE_EN]),
    .edge_fall (ctrl_q[F_EDGE_PL]),
    .src_tick  (src_tick),
    .sync_edge (edge_reload)
  );

  art_prescaler #(.SELW(PSW)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_tick (src_tick),
    .sel      (ps_sel),
    .cnt_tick (cnt_tick)
  );

  art_core #(.DW(DW)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt_tick    (cnt_tick),
    .live_wr     (live_wr),
    .live_wdata  (bus_wdata),
    .edge_reload (edge_reload),
    .reload_val  (reload_q),
    .cmp_val     (cmp_q),
    .flag_clr    (flag_clr),
    .cnt         (cnt),
    .step        (step),
    .ovf_evt     (ovf_evt),
    .cmp_evt     (cmp_evt),
    .ovf_flag    (ovf_flag),
    .cmp_flag    (cmp_flag)
  );

  always_comb begin
    unique case (bus_addr)
      A_CTRL:   bus_rdata = ctrl_q;
      A_RELOAD: bus_rdata = reload_q;
      A_CMP:    bus_rdata = cmp_q;
      A_LIVE:   bus_rdata = cnt;
      A_FLAGS:  bus_rdata = {{(DW-2){1'b0}}, cmp_flag, ovf_flag};
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/art_timer_chk.sv
module art_timer_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] cnt,
  input logic [DW-1:0] reload_q,
  input logic [DW-1:0] ctrl_q,
  input logic [DW-1:0] bus_wdata,
  input logic          live_wr,
  input logic          edge_reload,
  input logic          cnt_tick,
  input logic          src_tick,
  input logic          ovf_evt,
  input logic [1:0]    flag_clr,
  input logic          ovf_flag
);
  localparam logic [DW-1:0] CMAX = '1;

  AST_OVF_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> cnt == $past(reload_q)); // R5

  AST_OVF_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ovf_flag); // R6

  AST_OVF_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && !flag_clr[0] |=> ovf_flag); // R6

  AST_LIVE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    live_wr |=> cnt == $past(bus_wdata)); // R8

  AST_LIVE_BEATS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    live_wr && !ovf_flag |=> !ovf_flag); // R10

  AST_EDGE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    edge_reload && !live_wr |=> cnt == $past(reload_q)); // R9

  AST_INCREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_tick && !live_wr && !edge_reload && cnt != CMAX
    |=> cnt == $past(cnt) + 1'b1); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_tick && !live_wr && !edge_reload |=> $stable(cnt)); // R8

  AST_SRC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[1:0] == 2'b11 |-> !src_tick); // R4

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[4] == 1'b0); // R3
endmodule

bind art_timer art_timer_chk #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cnt         (cnt),
  .reload_q    (reload_q),
  .ctrl_q      (ctrl_q),
  .bus_wdata   (bus_wdata),
  .live_wr     (live_wr),
  .edge_reload (edge_reload),
  .cnt_tick    (cnt_tick),
  .src_tick    (src_tick),
  .ovf_evt     (ovf_evt),
  .flag_clr    (flag_clr),
  .ovf_flag    (ovf_flag)
);

// File: tb/sim_art_timer.sv
`timescale 1ns/1ps
module sim_art_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       ext_pin = 1'b0;
  logic       ovf_flag;
  logic       cmp_flag;
  int         tests = 0;
  int         fails = 0;

  localparam logic [2:0] CTRL = 3'd0, RELOAD = 3'd1, CMP = 3'd2, LIVE = 3'd3, FLAGS = 3'd4;

  always #2.5 clk = ~clk;

  art_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_pin(ext_pin),
    .ovf_flag(ovf_flag), .cmp_flag(cmp_flag)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    #1 bus_addr = a;
    #0.4 d = bus_rdata;
  endtask

  task automatic pulses(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk) ext_pin = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk) ext_pin = 1'b0;
      repeat (3) @(posedge clk);
    end
  endtask

  task automatic edge_to(input logic lvl);
    @(negedge clk) ext_pin = lvl;
    repeat (5) @(posedge clk);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(posedge clk);
    rd(CTRL, v);   chk("R11 ctrl after reset", v, 8'h00);
    rd(RELOAD, v); chk("R11 reload after reset", v, 8'h00);
    rd(CMP, v);    chk("R11 compare after reset", v, 8'h00);
    rd(FLAGS, v);  chk("R11 flags after reset", v, 8'h00);
    @(negedge clk) rst_n = 1'b1;

    // R1 R3: field layout and reserved bit
    wr(CTRL, 8'hFF); rd(CTRL, v); chk("R3 reserved bit reads zero", v, 8'hEF);
    wr(CTRL, 8'h03);
    wr(RELOAD, 8'h5C); rd(RELOAD, v); chk("R1 reload readback", v, 8'h5C);
    wr(CMP, 8'h10);    rd(CMP, v);    chk("R1 compare readback", v, 8'h10);

    // R2 R4: prescaler sweep on the core clock and on divide-by-three
    for (int src = 0; src < 2; src++) begin
      for (int n = 0; n < 8; n++) begin
        int w;
        w = 5 * (1 << n) * ((src == 1) ? 3 : 1);
        wr(CTRL, 8'((n << 5) | 3));
        wr(LIVE, 8'h20);
        wr(CTRL, 8'((n << 5) | src));
        repeat (w) @(posedge clk);
        rd(LIVE, v);
        chk($sformatf("R2 R4 src=%0d ratio=%0d", src, 1 << n), v, 8'h25);
      end
    end

    // R4: external pin as clock, ratio 1 and 2
    wr(CTRL, 8'h03); wr(LIVE, 8'h30); wr(CTRL, 8'h02);
    pulses(5); repeat (4) @(posedge clk);
    rd(LIVE, v); chk("R4 pin clock 5 edges", v, 8'h35);
    wr(CTRL, 8'h03); wr(LIVE, 8'h30); wr(CTRL, 8'h22);
    pulses(6); repeat (4) @(posedge clk);
    rd(LIVE, v); chk("R2 R4 pin clock ratio 2", v, 8'h33);
    // R4: source off stands still
    wr(CTRL, 8'h03); repeat (20) @(posedge clk);
    rd(LIVE, v); chk("R4 source off holds", v, 8'h33);

    // R5 R6: overflow reload and sticky flag
    wr(RELOAD, 8'h40); wr(CMP, 8'h30); wr(LIVE, 8'hFC); wr(FLAGS, 8'h03);
    wr(CTRL, 8'h00);
    repeat (3) @(posedge clk);
    rd(LIVE, v);  chk("R5 count before overflow", v, 8'hFF);
    rd(FLAGS, v); chk("R6 no flag before overflow", v, 8'h00);
    @(posedge clk);
    rd(LIVE, v);  chk("R5 reload on overflow", v, 8'h40);
    rd(FLAGS, v); chk("R6 overflow flag set", v, 8'h01);
    wr(CTRL, 8'h03);
    repeat (3) @(posedge clk);
    rd(FLAGS, v); chk("R6 overflow flag sticky", v, 8'h01);
    wr(FLAGS, 8'h01); rd(FLAGS, v); chk("R6 overflow flag cleared", v, 8'h00);

    // R7: compare match
    wr(CMP, 8'h10); wr(LIVE, 8'h0D);
    wr(CTRL, 8'h00);
    repeat (2) @(posedge clk);
    rd(FLAGS, v); chk("R7 no match at 0F", v, 8'h00);
    @(posedge clk);
    rd(FLAGS, v); chk("R7 match flag at 10", v, 8'h02);
    wr(CTRL, 8'h03);
    wr(FLAGS, 8'h02); rd(FLAGS, v); chk("R7 match flag cleared", v, 8'h00);

    // R8 R10: live write on the fly, beating an overflow step
    wr(CTRL, 8'h00);
    wr(LIVE, 8'hFF);
    wr(LIVE, 8'h20);
    wr(CTRL, 8'h03);
    rd(LIVE, v);  chk("R8 counting resumes from written value", v, 8'h21);
    rd(FLAGS, v); chk("R10 write wins over overflow", v, 8'h00);

    // R9: edge synchronization
    wr(RELOAD, 8'h77);
    wr(CTRL, 8'h07); wr(LIVE, 8'h05);
    edge_to(1'b1); rd(LIVE, v); chk("R9 rising edge reloads", v, 8'h77);
    wr(LIVE, 8'h05);
    edge_to(1'b0); rd(LIVE, v); chk("R9 falling edge ignored when rising", v, 8'h05);
    wr(CTRL, 8'h0F);
    edge_to(1'b1); rd(LIVE, v); chk("R9 rising edge ignored when falling", v, 8'h05);
    edge_to(1'b0); rd(LIVE, v); chk("R9 falling edge reloads", v, 8'h77);
    wr(CTRL, 8'h0B); wr(LIVE, 8'h05);
    edge_to(1'b1); edge_to(1'b0); rd(LIVE, v); chk("R9 disabled edges ignored", v, 8'h05);

    // R11: reset keeps the count and stops counting
    wr(CTRL, 8'h03); wr(LIVE, 8'h5A);
    @(negedge clk) rst_n = 1'b0;
    repeat (4) @(posedge clk);
    rd(LIVE, v); chk("R11 count kept in reset", v, 8'h5A);
    rd(CTRL, v); chk("R11 ctrl cleared", v, 8'h00);
    repeat (4) @(posedge clk);
    rd(LIVE, v); chk("R11 no counting in reset", v, 8'h5A);
    @(negedge clk) rst_n = 1'b1;

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule